// File: doc/BRIEF.md
# Banked GPIO Controller with Edge/Level Interrupts

The block manages a configurable number of banks, each holding 16 general-purpose pins, behind a 32-bit register bus. Every bank has an identical group of per-pin control words. These words set which pins drive, which inputs are listened to, and which pins software has claimed for data access. They also select how each pin raises an interrupt: on a level of either sense, on one chosen edge, or on any change. Interrupt status is held raw and masked per bank, and a single combined interrupt line summarises every bank.

Pin inputs are resynchronised by two flops before they are used. Output drive and output enable come straight from the control words. A bus access is a one-cycle request. The response, with read data for reads, comes back on the following cycle.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every control and status bit is zero: `pin_oe` is all zero, `pin_out` is all zero, `irq` is low and every register reads zero.
- R2: Bank k occupies byte addresses k*0x80 upward, and a register is selected by address bits 6:2. The word offsets are 0x00 data, 0x04 claim mask, 0x08 direction, 0x0C level select, 0x10 both-edge, 0x14 polarity, 0x18 interrupt enable, 0x1C raw status, 0x20 masked status, 0x24 acknowledge and 0x28 input enable. Only bits 15:0 are stored, and bits 31:16 of read data are always zero.
- R3: A `bus_req` is answered by `bus_ready` high exactly one cycle later, with read data valid in that cycle. `bus_ready` is low in every other cycle.
- R4: A direction bit of 1 enables the pin's output: `pin_oe` mirrors the direction word. `pin_out` mirrors the output data register.
- R5: A write to the data word changes only the output data bits whose claim bit is 1. The other output data bits keep their values.
- R6: A read of the data word returns, per pin, the synchronised input when direction=0, input enable=1 and claim=1, the output data bit when direction=1 and claim=1, and 0 otherwise.
- R7: The pin input reaches the data read path through two flops. A read accepted on the first or second rising edge after a pin change returns the old level, and a read accepted on the third edge returns the new level.
- R8: With level select=1, the raw status bit follows the qualified level: the input when polarity=1, the inverted input when polarity=0.
- R9: With level select=0 and both-edge=0, a rising synchronised edge sets raw status when polarity=1, and a falling edge sets it when polarity=0.
- R10: With level select=0 and both-edge=1, either edge sets raw status whatever the polarity bit holds.
- R11: Masked status equals raw status AND interrupt enable. `irq` is the OR of all masked status bits of all banks.
- R12: Writing 1 to an acknowledge bit clears a latched edge status bit, and writing 0 leaves it set. The acknowledge word reads as zero. A level-mode status bit is not cleared by acknowledge.
- R13: An edge detected in the same cycle as an acknowledge write for that pin wins, so the status bit stays set.
- R14: A pin whose input enable is 0 raises no edge or level event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Bus access request for this cycle |
| bus_wen | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | Response strobe, one cycle after bus_req |
| pin_in | input | NUM_BANKS*16 | Asynchronous pin levels |
| pin_out | output | NUM_BANKS*16 | Output data to pads |
| pin_oe | output | NUM_BANKS*16 | Output enable to pads |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is an edge landing in exactly the same cycle as an acknowledge write for that pin. The edge appears two rising edges after the pin moves. The bench changes the pin on a falling edge, counts two rising edges, and then places the acknowledge request so it is taken on the third. A second acknowledge one cycle later must then clear the bit. Randomised rounds apply a new mode, polarity, enable and pin pattern to a random bank. Each round first clears stale status, then flips the pins once. The raw and masked status and `irq` are then checked against a reference that compares the old and new pin patterns.

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int NUM_BANKS = 16,
  localparam int BANK_BITS = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W = 7 + BANK_BITS,
  localparam int NP = NUM_BANKS * 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready,
  input  logic [NP-1:0]     pin_in,
  output logic [NP-1:0]     pin_out,
  output logic [NP-1:0]     pin_oe,
  output logic              irq
);
  localparam logic [4:0] W_DATA = 5'd0, W_CLAIM = 5'd1, W_DIR = 5'd2, W_LVL = 5'd3,
                         W_BOTH = 5'd4, W_POL = 5'd5, W_IEN = 5'd6, W_RAW = 5'd7,
                         W_MSK = 5'd8, W_ACK = 5'd9, W_INEN = 5'd10;

  logic [BANK_BITS-1:0] bsel;
  logic [4:0]           ridx;
  logic [NP-1:0]        raw_all, lvl_all, ien_all, inen_all, rd_flat;

  assign bsel = bus_addr[ADDR_W-1:7];
  assign ridx = bus_addr[6:2];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int L = b * 16;
    logic [15:0] out_r, claim_r, dir_r, lvl_r, both_r, pol_r, ien_r, raw_r, inen_r;
    logic [15:0] sy1, sy2, sy3, clr, rise, fall, lv_hit, ed_hit, raw_n, rd_w;
    logic        wr;
    logic [15:0] wd;

    assign wr     = bus_req && bus_wen && (bsel == BANK_BITS'(b));
    assign wd     = bus_wdata[15:0];
    assign clr    = (wr && ridx == W_ACK) ? wd : 16'h0;
    assign rise   = sy2 & ~sy3;
    assign fall   = ~sy2 & sy3;
    assign lv_hit = (pol_r & sy2) | (~pol_r & ~sy2);
    assign ed_hit = (both_r & (rise | fall)) | (~both_r & ((pol_r & rise) | (~pol_r & fall)));
    assign raw_n  = (lvl_r & inen_r & lv_hit) | (~lvl_r & ((inen_r & ed_hit) | (raw_r & ~clr)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_r <= '0; claim_r <= '0; dir_r <= '0; lvl_r <= '0; both_r <= '0;
        pol_r <= '0; ien_r <= '0; raw_r <= '0; inen_r <= '0;
        sy1 <= '0; sy2 <= '0; sy3 <= '0;
      end else begin
        sy1   <= pin_in[L +: 16];
        sy2   <= sy1;
        sy3   <= sy2;
        raw_r <= raw_n;
        if (wr) begin
          case (ridx)
            W_DATA:  out_r   <= (out_r & ~claim_r) | (wd & claim_r);
            W_CLAIM: claim_r <= wd;
            W_DIR:   dir_r   <= wd;
            W_LVL:   lvl_r   <= wd;
            W_BOTH:  both_r  <= wd;
            W_POL:   pol_r   <= wd;
            W_IEN:   ien_r   <= wd;
            W_INEN:  inen_r  <= wd;
            default: ;
          endcase
        end
      end
    end

    always_comb begin
      case (ridx)
        W_DATA:  rd_w = claim_r & ((~dir_r & inen_r & sy2) | (dir_r & out_r));
        W_CLAIM: rd_w = claim_r;
        W_DIR:   rd_w = dir_r;
        W_LVL:   rd_w = lvl_r;
        W_BOTH:  rd_w = both_r;
        W_POL:   rd_w = pol_r;
        W_IEN:   rd_w = ien_r;
        W_RAW:   rd_w = raw_r;
        W_MSK:   rd_w = raw_r & ien_r;
        W_INEN:  rd_w = inen_r;
        default: rd_w = 16'h0;
      endcase
    end

    assign rd_flat[L +: 16]  = rd_w;
    assign pin_out[L +: 16]  = out_r;
    assign pin_oe[L +: 16]   = dir_r;
    assign raw_all[L +: 16]  = raw_r;
    assign lvl_all[L +: 16]  = lvl_r;
    assign ien_all[L +: 16]  = ien_r;
    assign inen_all[L +: 16] = inen_r;
  end

  assign irq = |(raw_all & ien_all);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_ready <= 1'b0;
    end else begin
      bus_ready <= bus_req;
      if (bus_req && !bus_wen && int'(bsel) < NUM_BANKS)
        bus_rdata <= {16'h0, rd_flat[int'(bsel)*16 +: 16]};
      else
        bus_rdata <= '0;
    end
  end
endmodule

module gpio_bank_ctrl_chk #(parameter int NP = 256) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_wen,
  input logic          bus_ready,
  input logic [31:0]   bus_rdata,
  input logic [NP-1:0] pin_oe,
  input logic [NP-1:0] pin_out,
  input logic          irq,
  input logic [NP-1:0] raw,
  input logic [NP-1:0] lvl,
  input logic [NP-1:0] ien,
  input logic [NP-1:0] inen
);
  // R3
  ready_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_req |=> bus_ready);
  // R3
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !bus_req |=> !bus_ready);
  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_ready |-> bus_rdata[31:16] == 16'h0);
  // R4
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !(bus_req && bus_wen) |=> $stable(pin_oe));
  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !(bus_req && bus_wen) |=> $stable(pin_out));
  // R12
  edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_wen) |=> ((($past(raw) & ~lvl) & ~raw) == '0));
  // R14
  no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_wen) |=> ((raw & ~$past(raw) & ~inen) == '0));
  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) (ien == '0) |-> !irq);
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NP(NP)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wen(bus_wen), .bus_ready(bus_ready),
  .bus_rdata(bus_rdata), .pin_oe(pin_oe), .pin_out(pin_out), .irq(irq),
  .raw(raw_all), .lvl(lvl_all), .ien(ien_all), .inen(inen_all)
);

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;
  localparam int NB = 16;
  localparam int NP = NB * 16;
  localparam int AW = 11;
  localparam int O_DATA = 0, O_CLAIM = 1, O_DIR = 2, O_LVL = 3, O_BOTH = 4, O_POL = 5,
                 O_IEN = 6, O_RAW = 7, O_MSK = 8, O_ACK = 9, O_INEN = 10;

  logic clk = 0, rst_n = 0, bus_req = 0, bus_wen = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_ready, irq;
  logic [NP-1:0] pin_in = '0, pin_out, pin_oe;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] m_out[NB], m_claim[NB], m_dir[NB], m_inen[NB];

  gpio_bank_ctrl #(.NUM_BANKS(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int b, input int idx, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_wen = 1; bus_addr = AW'(b * 128 + idx * 4); bus_wdata = d;
    @(posedge clk); #1;
    bus_req = 0; bus_wen = 0;
  endtask

  task automatic rd(input int b, input int idx, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_wen = 0; bus_addr = AW'(b * 128 + idx * 4);
    @(posedge clk);
    @(negedge clk);
    if (bus_ready !== 1'b1) begin
      checks++; fails++;
      $display("FAIL R3: got ready %b expected 1", bus_ready);
    end
    d = bus_rdata;
    bus_req = 0;
  endtask

  function automatic logic [15:0] exp_data(input int b, input logic [15:0] p);
    return m_claim[b] & ((~m_dir[b] & m_inen[b] & p) | (m_dir[b] & m_out[b]));
  endfunction

  function automatic logic [15:0] exp_raw(input logic [15:0] lv, both, pol, inen, oldp, newp);
    logic [15:0] r, f, lh, eh;
    r  = newp & ~oldp;
    f  = ~newp & oldp;
    lh = (pol & newp) | (~pol & ~newp);
    eh = (both & (r | f)) | (~both & ((pol & r) | (~pol & f)));
    return inen & ((lv & lh) | (~lv & eh));
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    logic [15:0] oldp, newp, lv, bo, po, ie, en, e;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < NB; i++) begin m_out[i] = 0; m_claim[i] = 0; m_dir[i] = 0; m_inen[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    @(negedge clk);
    chk("R1 oe", pin_oe[31:0], 0);
    chk("R1 out", pin_out[31:0], 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R3 idle ready", {31'b0, bus_ready}, 0);
    rd(3, O_DIR, d);  chk("R1 dir", d, 0);
    rd(3, O_INEN, d); chk("R1 inen", d, 0);
    rd(3, O_RAW, d);  chk("R1 raw", d, 0);

    // R2 bank stride and upper bits; R4 oe
    wr(5, O_DIR, 32'hFFFF_FFFF); m_dir[5] = 16'hFFFF;
    rd(5, O_DIR, d); chk("R2 stride/upper", d, 32'h0000_FFFF);
    rd(4, O_DIR, d); chk("R2 neighbour bank", d, 0);
    rd(5, O_ACK, d); chk("R12 ack reads zero", d, 0);
    rd(5, 12, d);    chk("R2 unused offset", d, 0);
    chk("R4 oe bank5", pin_oe[80 +: 16], 16'hFFFF);

    // R5 claim-gated data write
    wr(5, O_CLAIM, 32'h0000_00FF); m_claim[5] = 16'h00FF;
    wr(5, O_DATA, 32'h0000_A5A5);  m_out[5] = 16'h00A5;
    wr(5, O_CLAIM, 32'h0000_FFFF); m_claim[5] = 16'hFFFF;
    @(negedge clk);
    chk("R5 pin_out gated", pin_out[80 +: 16], 16'h00A5);
    rd(5, O_DATA, d); chk("R6 output readback", d, 32'h0000_00A5);

    // R7 synchroniser latency
    wr(2, O_CLAIM, 32'hFFFF); m_claim[2] = 16'hFFFF;
    wr(2, O_INEN, 32'hFFFF);  m_inen[2] = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    pin_in[32 +: 16] = 16'h3C3C;
    bus_req = 1; bus_wen = 0; bus_addr = AW'(2 * 128);
    @(negedge clk); chk("R7 edge1 old", bus_rdata, 0);
    @(negedge clk); chk("R7 edge2 old", bus_rdata, 0);
    @(negedge clk); chk("R7 edge3 new", bus_rdata, 32'h3C3C);
    bus_req = 0;

    // R4 R5 R6 random data path
    for (int it = 0; it < 40; it++) begin
      int b;
      logic [15:0] cl, dr, en2, dd, pp;
      b = $urandom_range(NB - 1);
      cl = 16'($urandom); dr = 16'($urandom); en2 = 16'($urandom); dd = 16'($urandom); pp = 16'($urandom);
      if (it % 8 == 0) cl = 16'h0000;
      wr(b, O_CLAIM, {16'hDEAD, cl}); m_claim[b] = cl;
      wr(b, O_DIR, {16'h0, dr});      m_dir[b] = dr;
      wr(b, O_INEN, {16'h0, en2});    m_inen[b] = en2;
      wr(b, O_DATA, {16'h0, dd});     m_out[b] = (m_out[b] & ~cl) | (dd & cl);
      pin_in[b*16 +: 16] = pp;
      repeat (3) @(posedge clk);
      rd(b, O_DATA, d);
      chk("R6 data read", d, {16'h0, exp_data(b, pp)});
      chk("R4 oe", pin_oe[b*16 +: 16], dr);
      chk("R5 out", pin_out[b*16 +: 16], m_out[b]);
    end

    // R13 edge and acknowledge in the same cycle, then R12 clear
    wr(7, O_LVL, 0); wr(7, O_BOTH, 0); wr(7, O_POL, 32'h1); wr(7, O_INEN, 32'h1);
    pin_in[112 +: 16] = 0;
    repeat (4) @(posedge clk);
    wr(7, O_ACK, 32'hFFFF);
    @(negedge clk);
    pin_in[112] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(7, O_ACK, 32'h1);
    rd(7, O_RAW, d); chk("R13 edge wins over ack", d, 32'h1);
    wr(7, O_ACK, 32'h0);
    rd(7, O_RAW, d); chk("R12 ack zero no effect", d, 32'h1);
    wr(7, O_ACK, 32'h1);
    rd(7, O_RAW, d); chk("R12 ack clears edge", d, 0);

    // R12 level status not clearable; R11 irq
    wr(7, O_LVL, 32'h1);
    wr(7, O_IEN, 32'h1);
    repeat (3) @(posedge clk);
    wr(7, O_ACK, 32'h1);
    rd(7, O_RAW, d); chk("R12 level survives ack", d, 32'h1);
    chk("R11 irq level", {31'b0, irq}, 1);
    wr(7, O_IEN, 0);
    @(negedge clk); chk("R11 irq masked", {31'b0, irq}, 0);
    wr(7, O_LVL, 0); wr(7, O_ACK, 32'hFFFF);

    // R8 R9 R10 R11 R14 random interrupt rounds
    for (int it = 0; it < 60; it++) begin
      int b;
      b = $urandom_range(NB - 1);
      oldp = pin_in[b*16 +: 16];
      lv = 16'($urandom); bo = 16'($urandom); po = 16'($urandom); en = 16'($urandom); ie = 16'($urandom);
      if (it % 10 == 0) en = 0;
      wr(b, O_LVL, {16'h0, lv}); wr(b, O_BOTH, {16'h0, bo}); wr(b, O_POL, {16'h0, po});
      wr(b, O_INEN, {16'h0, en}); wr(b, O_IEN, {16'h0, ie});
      repeat (4) @(posedge clk);
      wr(b, O_ACK, 32'hFFFF);
      newp = 16'($urandom);
      @(negedge clk);
      pin_in[b*16 +: 16] = newp;
      repeat (5) @(posedge clk);
      e = exp_raw(lv, bo, po, en, oldp, newp);
      rd(b, O_RAW, d); chk("R8/R9/R10/R14 raw", d, {16'h0, e});
      rd(b, O_MSK, d); chk("R11 masked", d, {16'h0, e & ie});
      chk("R11 irq", {31'b0, irq}, {31'b0, |(e & ie)});
      wr(b, O_IEN, 0);
      wr(b, O_LVL, 0);
      wr(b, O_ACK, 32'hFFFF);
    end

    done = 1;
    finish_run();
  end
endmodule